// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a small synchronous burst SRAM. Its 36-bit word is made of four 9-bit byte lanes. All control, address and write data inputs are taken on the rising clock edge. A burst starts on one of two address strobes. The read-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls in the same cycle. Later words in the burst take their addresses from an internal two-bit counter. The counter moves only when the advance input is asserted, and it runs in either linear or interleaved order.

Read data passes through a registered output stage. After the last read, the output stays driven for one further cycle, which is a double-cycle deselect. A separate output enable blanks the outputs at once, with no clock edge needed. The data-out valid flag stands in for the tri-state drivers of a real device: when the flag is low, the data outputs read zero.

Top module: `pburst_sram`

## Requirements
- R1: A read whose address is taken at rising edge k puts that word on `rdata_o`, with `rvalid_o` high, right after edge k+1. Each further read cycle in the burst gives one more word per clock.
- R2: The address and the three select inputs are taken only in a cycle where `pstrobe_n` or `cstrobe_n` is low. In a cycle with no strobe, they are ignored and the burst in progress continues.
- R3: In a cycle with no strobe, the burst address steps only when `adv_n` is low. With `adv_n` high, the same address is accessed again.
- R4: The upper address bits of a burst stay fixed. The lower two bits are the start value plus the step count modulo 4 when `burst_lin_i` is 1, and the start value XOR the step count when it is 0. `burst_lin_i` is held constant during a burst.
- R5: A write is started by `cstrobe_n` together with an active write control, or made in any later no-strobe cycle of a burst. The word is stored at the current burst address on that same edge, with no further strobe, and a read in the next cycle returns it.
- R6: Lane l is bits [9l+8:9l]. In a write, lane l is written when `lane_wr_n` is 0 and `lane_en_n[l]` is 0. Every other lane keeps its old contents. With `lane_wr_n` at 1, `lane_en_n` has no effect.
- R7: When `all_wr_n` is 0, all four lanes are written, whatever `lane_wr_n` and `lane_en_n` hold.
- R8: A cycle with `pstrobe_n` low is always a read, even when `cstrobe_n` or write controls are also active. A write in that burst needs the write controls in a later, no-strobe cycle.
- R9: The device is selected when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe seen while it is not selected ends any burst, and later no-strobe cycles neither read nor write.
- R10: If the last read is taken at edge k, `rvalid_o` stays high after edge k+2, holding the last word, and goes low after edge k+3.
- R11: While `oe_n` is high, `rvalid_o` is 0 and `rdata_o` is zero, and both change without waiting for a clock edge.
- R12: During and right after reset, `rvalid_o` is 0, `rdata_o` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Start address of a burst |
| wdata_i | input | 36 | Write word, four 9-bit lanes |
| sel_a_n | input | 1 | Primary select, active low |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| pstrobe_n | input | 1 | Read-only address strobe, active low, has priority |
| cstrobe_n | input | 1 | Read/write address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| lane_wr_n | input | 1 | Qualifier for the lane enables, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| burst_lin_i | input | 1 | 1 selects linear order, 0 selects interleaved order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read word, zero when not driven |
| rvalid_o | output | 1 | Data outputs are driven |

## Verification
The bench first fills part of the array with full-word bursts. It then reads the contents back with linear, interleaved and suspended bursts, which separates the two orderings and catches an advance that is ignored or wrongly taken. Partial-lane writes, a global write with every lane disabled, and a read strobe that carries write controls show whether lane masking, override and strobe priority are wired the right way round. A burst ended by a deselected strobe and then fed write controls, a burst continued with changed address and selects, and an output-enable pulse in the middle of a burst test what the block must ignore. Every clock is compared against a behavioural model, so the cycle on which the outputs turn off after a deselect is checked exactly.

// File: rtl/pburst_sram_pkg.sv
// Shared definitions for the pipelined burst SRAM.
// Assumes: nothing beyond IEEE 1800-2017.
package pburst_sram_pkg;

    // Kind of array access made on one clock edge
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

endpackage

// File: rtl/pburst_sram_ctrl.sv
// Strobe, select and write-control decoder.
// Works out, for every edge, whether a burst is loaded, stepped, killed,
// and whether the array is read or which lanes are written.
// Assumes: all inputs are stable around the rising edge.
module pburst_sram_ctrl
    import pburst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             pstrobe_n,
    input  logic             cstrobe_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] lane_en_n,
    input  logic             lane_wr_n,
    input  logic             all_wr_n,
    output logic             load,
    output logic             step,
    output logic             rd_req,
    output logic [LANES-1:0] lane_we
);

    logic             selected;
    logic             strobe;
    logic             burst_on_q;
    logic [LANES-1:0] lane_mask;
    logic             wr_any;
    acc_kind_t        acc;

    // Decode the select and strobe pins
    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        strobe   = !pstrobe_n || !cstrobe_n;
        load     = strobe && selected;
        step     = !strobe && burst_on_q && !adv_n;
    end

    // Work out which lanes the write controls ask for
    always_comb begin
        if (!all_wr_n) begin
            lane_mask = '1;
        end else if (!lane_wr_n) begin
            lane_mask = ~lane_en_n;
        end else begin
            lane_mask = '0;
        end
        wr_any = |lane_mask;
    end

    // Pick the access kind for this edge; the read strobe never writes
    always_comb begin
        acc = ACC_NONE;
        if (load) begin
            acc = (!pstrobe_n || !wr_any) ? ACC_READ : ACC_WRITE;
        end else if (!strobe && burst_on_q) begin
            acc = wr_any ? ACC_WRITE : ACC_READ;
        end
        rd_req  = (acc == ACC_READ);
        lane_we = (acc == ACC_WRITE) ? lane_mask : '0;
    end

    // Track whether a burst is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_on_q <= 1'b0;
        end else if (strobe) begin
            burst_on_q <= selected;
        end
    end

endmodule

// File: rtl/pburst_sram_burst_ctr.sv
// Burst address generator.
// Holds the start address and a step count, and gives the address used
// on the current edge in linear or interleaved order.
// Assumes: the order input does not change during a burst.
module pburst_sram_burst_ctr #(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;
    logic [ADDR_W-1:0]  src;
    logic [BURST_W-1:0] low;

    // Form the address of this edge from the start value and count
    always_comb begin
        cnt_nxt = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
        src     = load ? addr_i : base_q;
        low     = linear ? (src[BURST_W-1:0] + cnt_nxt)
                         : (src[BURST_W-1:0] ^ cnt_nxt);
        acc_addr = {src[ADDR_W-1:BURST_W], low};
    end

    // Keep the start address and the step count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) begin
                base_q <= addr_i;
            end
            if (load || step) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/pburst_sram_array.sv
// Lane-split storage array with a registered read stage.
// Each lane is its own memory, so writes of any lane mix leave the other lanes
// untouched. A read fills the stage register on the same edge.
// Assumes: a read and a write never fall on the same edge.
module pburst_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    rd_req,
    output logic [LANES*LANE_W-1:0] rd_data_s1,
    output logic                    rd_en_s1
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES*LANE_W-1:0] rd_word;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its write enable is set
        always_ff @(posedge clk) begin
            if (lane_we[l]) begin
                mem[addr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rd_word[l*LANE_W +: LANE_W] = mem[addr];
    end

    // First read pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_s1   <= 1'b0;
            rd_data_s1 <= '0;
        end else begin
            rd_en_s1 <= rd_req;
            if (rd_req) begin
                rd_data_s1 <= rd_word;
            end
        end
    end

endmodule

// File: rtl/pburst_sram_out.sv
// Output register with a two-stage drive enable and asynchronous gating.
// The second enable stage keeps the drivers on for one cycle after the last
// read. The output enable blanks the outputs without a clock edge.
// Assumes: rd_en_s1 and rd_data_s1 come straight from the read stage.
module pburst_sram_out #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_s1,
    input  logic [DATA_W-1:0] rd_data_s1,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic              en_q1;
    logic              en_q2;
    logic [DATA_W-1:0] rdata_q;

    // Output register and its drive-enable pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q1   <= 1'b0;
            en_q2   <= 1'b0;
            rdata_q <= '0;
        end else begin
            en_q1 <= rd_en_s1;
            en_q2 <= en_q1;
            if (rd_en_s1) begin
                rdata_q <= rd_data_s1;
            end
        end
    end

    // Gate the drivers with the asynchronous output enable
    always_comb begin
        rvalid_o = !oe_n && (en_q1 || en_q2);
        rdata_o  = rvalid_o ? rdata_q : '0;
    end

endmodule

// File: rtl/pburst_sram.sv
// Top level of the pipelined burst synchronous SRAM.
// Ties together the decoder, the burst counter, the lane array and the output stage.
// Assumes: synchronous active-low reset; the array contents are not reset.
module pburst_sram #(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    pstrobe_n,
    input  logic                    cstrobe_n,
    input  logic                    adv_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    lane_wr_n,
    input  logic                    all_wr_n,
    input  logic                    burst_lin_i,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvalid_o
);

    localparam int DATA_W = LANES * LANE_W;

    logic              load;
    logic              step;
    logic              rd_req;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rd_data_s1;
    logic              rd_en_s1;

    pburst_sram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .pstrobe_n (pstrobe_n),
        .cstrobe_n (cstrobe_n),
        .adv_n     (adv_n),
        .lane_en_n (lane_en_n),
        .lane_wr_n (lane_wr_n),
        .all_wr_n  (all_wr_n),
        .load      (load),
        .step      (step),
        .rd_req    (rd_req),
        .lane_we   (lane_we)
    );

    pburst_sram_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .linear   (burst_lin_i),
        .addr_i   (addr_i),
        .acc_addr (acc_addr)
    );

    pburst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (acc_addr),
        .wdata      (wdata_i),
        .lane_we    (lane_we),
        .rd_req     (rd_req),
        .rd_data_s1 (rd_data_s1),
        .rd_en_s1   (rd_en_s1)
    );

    pburst_sram_out #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_s1   (rd_en_s1),
        .rd_data_s1 (rd_data_s1),
        .oe_n       (oe_n),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

endmodule

// File: rtl/pburst_sram_chk.sv
// Property checker for the pipelined burst SRAM, bound into the top level.
// Assumes: sampled on the rising edge; every property is off during reset.
module pburst_sram_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              pstrobe_n,
    input logic              cstrobe_n,
    input logic              all_wr_n,
    input logic              oe_n,
    input logic              rd_req,
    input logic [LANES-1:0]  lane_we,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o
);

    AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid_o && rdata_o == '0)); // R11

    AST_READ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ##1 (oe_n || rvalid_o)); // R1

    AST_EXTRA_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ##2 (oe_n || rvalid_o)); // R10

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0 && !all_wr_n) |-> (lane_we == '1)); // R7

    AST_PSTROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !pstrobe_n |-> (lane_we == '0)); // R8

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pstrobe_n || !cstrobe_n) && !(!sel_a_n && sel_b && !sel_c_n))
        |-> (!rd_req && lane_we == '0)); // R9

endmodule

bind pburst_sram pburst_sram_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .pstrobe_n (pstrobe_n),
    .cstrobe_n (cstrobe_n),
    .all_wr_n  (all_wr_n),
    .oe_n      (oe_n),
    .rd_req    (rd_req),
    .lane_we   (lane_we),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
);

// File: tb/pburst_sram_bench.sv
// Bench for pburst_sram: a behavioural reference model, compared on every clock.
module pburst_sram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [35:0] wdata_i = '0;
    logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic        pstrobe_n = 1'b1, cstrobe_n = 1'b1, adv_n = 1'b1;
    logic [3:0]  lane_en_n = 4'hF;
    logic        lane_wr_n = 1'b1, all_wr_n = 1'b1;
    logic        burst_lin_i = 1'b1, oe_n = 1'b0;
    logic [35:0] rdata_o;
    logic        rvalid_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R12";

    // reference model state
    logic [35:0] ref_mem [256];
    bit          m_open = 0;
    int          m_base = 0, m_cnt = 0;
    bit          s1_en = 0, q1 = 0, q2 = 0;
    logic [35:0] s1_d = '0, dq = '0;

    always #2.5 clk = ~clk;

    pburst_sram u_pburst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n), .adv_n(adv_n),
        .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n),
        .burst_lin_i(burst_lin_i), .oe_n(oe_n),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    function automatic logic [35:0] pat(int a, int salt);
        return {4'(salt), 8'(a), 8'hC3 ^ 8'(salt), 8'(~a), 8'h5A};
    endfunction

    // One model step for the edge that has just occurred
    task automatic model_edge();
        bit sel, strobe, acc, rd, wany;
        int addr;
        logic [3:0] mask;
        sel    = !sel_a_n && sel_b && !sel_c_n;
        strobe = !pstrobe_n || !cstrobe_n;
        mask   = !all_wr_n ? 4'hF : (!lane_wr_n ? ~lane_en_n : 4'h0);
        wany   = (mask != 0);
        acc = 0; rd = 0;
        if (strobe) begin
            if (sel) begin
                m_open = 1; m_base = addr_i; m_cnt = 0; acc = 1;
                rd = !pstrobe_n || !wany;
            end else begin
                m_open = 0;
            end
        end else if (m_open) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            acc = 1; rd = !wany;
        end
        if (burst_lin_i) addr = (m_base & ~3) | ((m_base + m_cnt) & 3);
        else             addr = (m_base & ~3) | ((m_base ^ m_cnt) & 3);
        q2 = q1;
        q1 = s1_en;
        if (s1_en) dq = s1_d;
        s1_en = acc && rd;
        if (acc && rd) s1_d = ref_mem[addr];
        if (acc && !rd)
            for (int l = 0; l < 4; l++)
                if (mask[l]) ref_mem[addr][l*9 +: 9] = wdata_i[l*9 +: 9];
    endtask

    task automatic compare();
        bit ev;
        logic [35:0] ed;
        ev = !oe_n && (q1 || q2);
        ed = ev ? dq : '0;
        checks++;
        if (rvalid_o !== ev || rdata_o !== ed) begin
            fails++;
            $display("FAIL %s rvalid=%0b/%0b rdata=%h/%h (actual/expected)",
                     cur_req, rvalid_o, ev, rdata_o, ed);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        pstrobe_n = 1; cstrobe_n = 1; adv_n = 1;
        all_wr_n = 1; lane_wr_n = 1; lane_en_n = 4'hF;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0; addr_i = 8'hFF;
    endtask

    task automatic rd_start(int a);
        quiet(); cstrobe_n = 0; addr_i = 8'(a); tick();
    endtask

    task automatic wr_start(int a, logic [35:0] d, bit gw, bit bwe, logic [3:0] be);
        quiet(); cstrobe_n = 0; addr_i = 8'(a); wdata_i = d;
        all_wr_n = gw; lane_wr_n = bwe; lane_en_n = be; tick();
    endtask

    task automatic cont(bit advn, bit gw, logic [35:0] d);
        quiet(); adv_n = advn; all_wr_n = gw; wdata_i = d; tick();
    endtask

    // Strobe while not selected, then let the outputs drain
    task automatic desel(int idle);
        quiet(); cstrobe_n = 0; sel_a_n = 1; tick();
        for (int i = 0; i < idle; i++) begin quiet(); tick(); end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_up();
    end

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        // R12: outputs quiet while in reset
        checks++;
        if (rvalid_o !== 1'b0 || rdata_o !== '0) begin
            fails++;
            $display("FAIL R12 rvalid=%0b/0 rdata=%h/0", rvalid_o, rdata_o);
        end
        rst_n = 1;
        tick(); tick();

        // R5: fill 0..15 with four linear full-word write bursts
        cur_req = "R5";
        for (int b = 0; b < 4; b++) begin
            wr_start(b*4, pat(b*4, 1), 0, 1, 4'hF);
            for (int i = 1; i < 4; i++) cont(0, 0, pat(b*4 + i, 1));
        end
        desel(1);

        // R1: linear read burst from 5 (5,6,7,4)
        cur_req = "R1";
        rd_start(5);
        for (int i = 0; i < 3; i++) cont(0, 1, '0);
        // R10: outputs stay on one extra cycle after the deselect
        cur_req = "R10";
        desel(4);

        // R4: interleaved read burst from 6 (6,7,4,5)
        cur_req = "R4";
        burst_lin_i = 0;
        rd_start(6);
        for (int i = 0; i < 3; i++) cont(0, 1, '0);
        desel(3);
        burst_lin_i = 1;

        // R3: suspended advance repeats the address
        cur_req = "R3";
        rd_start(9);
        cont(0, 1, '0); cont(1, 1, '0); cont(1, 1, '0); cont(0, 1, '0);
        desel(3);

        // R2: changed address and selects ignored with no strobe
        cur_req = "R2";
        rd_start(12);
        for (int i = 0; i < 3; i++) begin
            quiet(); adv_n = 0; addr_i = 8'h03; sel_a_n = 1; sel_c_n = 1; tick();
        end
        desel(3);

        // R6: lanes 0 and 2 written, then lane enables without qualifier
        cur_req = "R6";
        wr_start(2, 36'hF_FFFF_FFFF, 1, 0, 4'b1010);
        quiet(); lane_en_n = 4'h0; lane_wr_n = 1; wdata_i = '0; tick();
        desel(1);
        rd_start(2); desel(3);

        // R7: global write overrides disabled lanes
        cur_req = "R7";
        wr_start(3, 36'h1_2345_6789, 0, 0, 4'hF);
        desel(1);
        rd_start(3); desel(3);

        // R8: read strobe with write controls only reads; write follows
        cur_req = "R8";
        quiet(); pstrobe_n = 0; addr_i = 8'd1; all_wr_n = 0; wdata_i = 36'hA_AAAA_AAAA; tick();
        cont(1, 0, 36'h5_5555_5555);
        cont(1, 1, '0);
        quiet(); pstrobe_n = 0; cstrobe_n = 0; addr_i = 8'd0; all_wr_n = 0;
        wdata_i = 36'h0_BAD0_BAD0; tick();
        cont(1, 1, '0);
        desel(3);
        rd_start(0); desel(3);

        // R9: a deselected strobe ends the burst; later writes do nothing
        cur_req = "R9";
        rd_start(10);
        quiet(); pstrobe_n = 0; addr_i = 8'd10; sel_c_n = 1; tick();
        cont(1, 0, 36'h7_7777_7777); cont(0, 0, 36'h6_6666_6666);
        quiet(); tick(); tick();
        rd_start(10); cont(0, 1, '0); desel(3);

        // R11: output enable blanks the outputs without a clock edge
        cur_req = "R11";
        rd_start(4); cont(0, 1, '0);
        oe_n = 1; #1;
        checks++;
        if (rvalid_o !== 1'b0 || rdata_o !== '0) begin
            fails++;
            $display("FAIL R11 rvalid=%0b/0 rdata=%h/0", rvalid_o, rdata_o);
        end
        cont(0, 1, '0);
        oe_n = 0; #1; compare();
        cont(0, 1, '0);
        desel(4);

        finish_up();
    end

endmodule